// File: doc/BRIEF.md
# Fixed-Point Exponential Interpolator

This unit evaluates e^x for a signed 16-bit fixed-point operand with 11 fractional bits. It is meant for the non-positive arguments that a softmax stage produces after subtracting the row maximum. It uses no floating-point hardware. The operand is first limited to the interval from -8.0 to 0. Its magnitude is then split into a segment number and a 10-bit weight inside that segment. The result is interpolated along a straight line between two neighbouring points of a 17-point table of e^x.

Operands enter through a valid/ready port and results leave on a valid-only port. There is no back-pressure from the output side. Once reset has been released, `in_ready` goes high on the first clock edge and stays high. The unit therefore takes one operand on every cycle in which `in_valid` is high. Every accepted operand produces exactly one result, two cycles later, and results come out in the order the operands were accepted. An upstream stage that holds `in_valid` high while `in_ready` is low keeps its operand, and nothing is taken in that cycle.

Top module: `exp_interp`

## Requirements
- R1: Operands and results use two's-complement fixed point with 16 bits, 11 of them fractional (1.0 = 0x0800). Every result lies between 0x0000 and 0x0800.
- R2: While `rst` is high at a clock edge, `in_ready`, `out_valid` and `out_data` are 0 after that edge. From the first clock edge after reset is released, `in_ready` is 1 and stays 1.
- R3: An operand is accepted when `in_valid` and `in_ready` are both high at a rising edge. If it is accepted in cycle c, `out_valid` is high in cycle c+2 with its result, and results keep the acceptance order. `out_valid` is low in every cycle whose cycle c-2 accepted nothing.
- R4: Any operand above zero (sign bit clear and value not 0) gives 0x0800.
- R5: Any operand below -8.0 (signed value less than -16384) gives 0x0000.
- R6: For operands from -16384 to 0, the magnitude m = -x is split into a segment index i = m >> 10 (0 to 16) and a weight w = m mod 1024.
- R7: The table entries are t[k] = round(2048 * e^(-k/2)) for k = 0..16. An operand on a segment boundary (w = 0) gives exactly t[i], so 0 gives 2048 and -8.0 gives 1.
- R8: Inside the domain, the result is t[i] - floor(((t[i] - t[i+1]) * w + 512) / 1024), with t[17] taken as t[16].
- R9: Inside the domain, the result differs from 2048 * e^(x/2048) by at most 64 * e^(-i/2) + 2 LSB, which is the chord error of a half-unit segment plus rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | 16 | Operand x, signed, 11 fractional bits |
| out_valid | output | 1 | `out_data` carries a result this cycle |
| out_data | output | 16 | e^x, 11 fractional bits, never negative |

## Verification
The bench targets the segment edges: the operands just above and below a multiple of 0.5, the exact grid points, and -8.0 itself, where the last segment has no upper neighbour. A design that read the wrong neighbour, or mis-split the index and weight, would jump by a whole table step at these points. The operands 0, 1, -16384, -16385 and -32768 probe the clamp logic; a wrong sign or magnitude test would wrap large negatives to large positive results or return 1.0 for -8.0. Random bubbles in `in_valid` expose a pipeline that drops, repeats or reorders results, or that raises `out_valid` for an idle cycle. A full sweep of the domain against the real exponential catches rounding that truncates instead of rounding to nearest.

// File: rtl/exp_pkg.sv
package exp_pkg;

  // Number format
  localparam int EXP_W     = 16;
  localparam int EXP_FRAC  = 11;
  // Segment geometry: each segment spans 2^SEG_SHIFT LSB (0.5)
  localparam int SEG_SHIFT = 10;
  localparam int N_SEG     = 16;

  // Derived sizes
  localparam int IDX_W      = $clog2(N_SEG + 1);
  localparam int MAG_W      = EXP_W + 1;
  localparam int TAB_W      = EXP_FRAC + 1;
  localparam int PROD_W     = TAB_W + SEG_SHIFT;
  localparam int DOMAIN_MAG = N_SEG << SEG_SHIFT;
  localparam int ONE_VAL    = 1 << EXP_FRAC;
  localparam int HALF_STEP  = 1 << (SEG_SHIFT - 1);

  typedef struct packed {
    logic             sat_hi;
    logic             sat_lo;
    logic [IDX_W-1:0] idx;
    logic [SEG_SHIFT-1:0] wt;
  } split_t;

  typedef struct packed {
    logic                 sat_hi;
    logic                 sat_lo;
    logic [TAB_W-1:0]     base;
    logic [TAB_W-1:0]     drop;
    logic [SEG_SHIFT-1:0] wt;
  } stage_t;

  // round(2048 * e^(-k/2))
  function automatic logic [TAB_W-1:0] grid_value(input int k);
    logic [TAB_W-1:0] v;
    case (k)
      0:  v = TAB_W'(2048);
      1:  v = TAB_W'(1242);
      2:  v = TAB_W'(753);
      3:  v = TAB_W'(457);
      4:  v = TAB_W'(277);
      5:  v = TAB_W'(168);
      6:  v = TAB_W'(102);
      7:  v = TAB_W'(62);
      8:  v = TAB_W'(38);
      9:  v = TAB_W'(23);
      10: v = TAB_W'(14);
      11: v = TAB_W'(8);
      12: v = TAB_W'(5);
      13: v = TAB_W'(3);
      14: v = TAB_W'(2);
      15: v = TAB_W'(1);
      default: v = TAB_W'(1);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/exp_range_split.sv
module exp_range_split
  import exp_pkg::*;
(
  input  logic [EXP_W-1:0] x,
  output split_t           s
);

  logic signed [MAG_W-1:0] xs;
  logic        [MAG_W-1:0] mag;
  logic                    neg;

  always_comb begin
    neg = x[EXP_W-1];
    xs  = {x[EXP_W-1], x};
    mag = MAG_W'(-xs);
    // Above zero: saturate to 1.0
    s.sat_hi = !neg && (x != '0);
    // Below the table's lower end: flush to zero
    s.sat_lo = neg && (mag > MAG_W'(DOMAIN_MAG));
    s.idx    = mag[SEG_SHIFT +: IDX_W];
    s.wt     = mag[SEG_SHIFT-1:0];
  end

endmodule

// File: rtl/exp_seg_rom.sv
module exp_seg_rom
  import exp_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [TAB_W-1:0] base,
  output logic [TAB_W-1:0] drop
);

  logic [TAB_W-1:0] grid [0:N_SEG];

  for (genvar k = 0; k <= N_SEG; k++) begin : g_grid
    assign grid[k] = grid_value(k);
  end

  logic [IDX_W-1:0] idx_c;
  logic [IDX_W-1:0] idx_n;
  logic [TAB_W-1:0] upper;

  always_comb begin
    idx_c = (idx > IDX_W'(N_SEG)) ? IDX_W'(N_SEG) : idx;
    idx_n = (idx_c == IDX_W'(N_SEG)) ? idx_c : idx_c + IDX_W'(1);
    base  = grid[idx_c];
    upper = grid[idx_n];
    drop  = base - upper;
  end

endmodule

// File: rtl/exp_lerp.sv
module exp_lerp
  import exp_pkg::*;
(
  input  stage_t           st,
  output logic [EXP_W-1:0] y
);

  logic [PROD_W-1:0] prod;
  logic [TAB_W-1:0]  val;

  always_comb begin
    prod = PROD_W'(st.drop) * PROD_W'(st.wt);
    val  = st.base - TAB_W'((prod + PROD_W'(HALF_STEP)) >> SEG_SHIFT);
    if (st.sat_hi)      y = EXP_W'(ONE_VAL);
    else if (st.sat_lo) y = '0;
    else                y = EXP_W'(val);
  end

endmodule

// File: rtl/exp_interp.sv
module exp_interp
  import exp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EXP_W-1:0] in_data,
  output logic             out_valid,
  output logic [EXP_W-1:0] out_data
);

  split_t           sp;
  logic [TAB_W-1:0] base_c;
  logic [TAB_W-1:0] drop_c;
  stage_t           st_c;
  stage_t           st_q;
  logic             st_v;
  logic             rdy_q;
  logic [EXP_W-1:0] y_c;
  logic             take;

  assign take     = in_valid && rdy_q;
  assign in_ready = rdy_q;

  exp_range_split u_split (
    .x (in_data),
    .s (sp)
  );

  exp_seg_rom u_rom (
    .idx  (sp.idx),
    .base (base_c),
    .drop (drop_c)
  );

  always_comb begin
    st_c.sat_hi = sp.sat_hi;
    st_c.sat_lo = sp.sat_lo;
    st_c.base   = base_c;
    st_c.drop   = drop_c;
    st_c.wt     = sp.wt;
  end

  // Stage 1: lookup results
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      st_v  <= 1'b0;
      st_q  <= '0;
    end else begin
      rdy_q <= 1'b1;
      st_v  <= take;
      if (take) st_q <= st_c;
    end
  end

  exp_lerp u_lerp (
    .st (st_q),
    .y  (y_c)
  );

  // Stage 2: interpolated result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= st_v;
      if (st_v) out_data <= y_c;
    end
  end

endmodule

// File: rtl/exp_interp_chk.sv
module exp_interp_chk
  import exp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [EXP_W-1:0] in_data,
  input logic             out_valid,
  input logic [EXP_W-1:0] out_data
);

  logic fire;
  assign fire = in_valid && in_ready;

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    fire |=> ##1 out_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ##1 !out_valid);

  assert_result_range_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= EXP_W'(ONE_VAL)));

  assert_pos_sat_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && !in_data[EXP_W-1] && in_data != '0) |=> ##1 (out_data == EXP_W'(ONE_VAL)));

  assert_neg_flush_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && (int'($signed(in_data)) < -DOMAIN_MAG)) |=> ##1 (out_data == '0));

  assert_zero_point_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && in_data == '0) |=> ##1 (out_data == EXP_W'(ONE_VAL)));

endmodule

bind exp_interp exp_interp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/exp_interp_tb_top.sv
`timescale 1ns/1ps
module exp_interp_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;

  always #10 clk = ~clk;

  exp_interp dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int total = 0;
  int bad   = 0;
  int tab [0:16];
  bit    fq[$];
  int    eq[$];
  int    xq[$];
  string tq[$];
  int unsigned seed = 32'h1234_5677;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model(input int x);
    int m, i, w, d;
    if (x > 0) return 2048;
    if (x < -16384) return 0;
    m = -x;
    i = m >> 10;
    w = m % 1024;
    if (i == 16) return tab[16];
    d = tab[i] - tab[i+1];
    return tab[i] - ((d * w + 512) / 1024);
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  // Called at a falling edge: check the result due now, then drive.
  task automatic step(input bit v, input int x, input string tag);
    bit f; int e; int xx; string t;
    real r, tol, diff;
    check(in_ready == 1'b1, "R2 ready after reset", int'(in_ready), 1);
    if (fq.size() >= 2) begin
      f = fq.pop_front(); e = eq.pop_front(); xx = xq.pop_front(); t = tq.pop_front();
      check(out_valid == f, "R3 out_valid timing", int'(out_valid), int'(f));
      if (f && out_valid) begin
        check(int'(out_data) == e, {t, " result value"}, int'(out_data), e);
        if (xx <= 0 && xx >= -16384) begin
          r    = 2048.0 * $exp(real'(xx) / 2048.0);
          tol  = 64.0 * $exp(-0.5 * real'((-xx) >> 10)) + 2.0;
          diff = real'(out_data) - r;
          if (diff < 0.0) diff = -diff;
          check(diff <= tol, "R9 accuracy vs real exp", int'(out_data), $rtoi(r + 0.5));
        end
      end
    end else begin
      check(out_valid == 1'b0, "R3 no output before first result", int'(out_valid), 0);
    end
    in_valid = v;
    in_data  = 16'(x);
    fq.push_back(v); eq.push_back(model(x)); xq.push_back(x); tq.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k <= 16; k++) tab[k] = $rtoi(2048.0 * $exp(-0.5 * real'(k)) + 0.5);

    // R2: reset state, with the inputs active during reset
    in_valid = 1'b1;
    in_data  = 16'h0400;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R2 in_ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R2 out_valid in reset", int'(out_valid), 0);
    check(out_data == 16'h0, "R2 out_data in reset", int'(out_data), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);

    // R7: every grid point, including 0 and -8.0
    for (int k = 0; k <= 16; k++) step(1'b1, -k * 1024, "R7 grid");

    // R4: positive operands saturate
    step(1'b1, 1, "R4 positive");
    step(1'b1, 32767, "R4 positive");
    step(1'b1, 2048, "R4 positive");
    step(1'b1, 0, "R7 zero");

    // R5: below the domain flushes to zero
    step(1'b1, -16385, "R5 below domain");
    step(1'b1, -32768, "R5 below domain");
    step(1'b1, -20000, "R5 below domain");
    step(1'b1, -16384, "R7 lower end");

    // R6: both sides of segment boundaries
    step(1'b1, -1, "R6 split");
    step(1'b1, -1023, "R6 split");
    step(1'b1, -1025, "R6 split");
    step(1'b1, -15359, "R6 split");
    step(1'b1, -15361, "R6 split");
    step(1'b1, -16383, "R6 split");

    // R3: bubbles and mixed operands
    for (int n = 0; n < 4000; n++) begin
      int a, b;
      a = next_rand();
      b = next_rand();
      step(a[3:0] > 4'd5, 300 - (b % 17500), "R3 stream");
    end

    // R8: every operand of the domain
    for (int x = 0; x >= -16384; x--) step(1'b1, x, "R8 sweep");

    // Drain
    repeat (3) step(1'b0, 0, "R3 drain");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule